// File: doc/BRIEF.md
# Round-Robin Neuron Result Collector

This block gathers finished accumulation results from a window of neurons and streams them to a downstream calculation stage. After a start pulse it captures its configuration. It then visits the neurons of the window one at a time in a fixed cyclic order. At each position it waits for that neuron to report a ready result, takes the result and acknowledges it with a one-cycle pulse. The result goes into an output register together with the bias word of the output it belongs to and a finish marker.

The block works in two modes. In per-result mode every neuron result is a complete output. In fully connected mode the block counts the results and groups them: a configured number of consecutive results form the parts of one output. The finish marker is raised only on the last part of a group. For each output the bias is read once from a bias memory with one cycle of read latency, at `base + output_index`. The run ends when the configured number of outputs has been handed downstream. The block then pulses `done_o` and becomes idle again.

Top module: `nrn_result_collector`

## Requirements
- R1: While reset is held and right after it, `out_valid_o`, `nrn_ack_o`, `bias_rd_en_o`, `busy_o` and `done_o` are all 0.
- R2: Neurons are polled starting at `cfg_first_i` and stepping up by one through `cfg_first_i + cfg_count_i - 1`, then wrapping to `cfg_first_i`. Results reach the output in exactly that order.
- R3: While the neuron at the polling position is not ready, no neuron is acknowledged and the position does not move, even if other neurons are ready. An acknowledge only goes to a neuron whose ready is high.
- R4: `nrn_ack_o` has at most one bit set. It pulses for exactly the cycle in which that neuron's `nrn_data_i` slice (bits `i*DATA_W +: DATA_W`) is taken.
- R5: With `cfg_fc_i`=0, every output carries `out_last_o`=1.
- R6: With `cfg_fc_i`=1, each output is made of `cfg_group_i` consecutive results. Only the last of them carries `out_last_o`=1.
- R7: For output k the block issues one bias read at address `cfg_bias_base_i + k`. Every part of that output carries the returned word on `out_bias_o`.
- R8: While `out_valid_o`=1 and `out_ready_i`=0, `out_valid_o`, `out_data_o`, `out_bias_o` and `out_last_o` hold their values.
- R9: After `cfg_outputs_i` outputs have completed a handshake, `done_o` pulses for one cycle, `busy_o` falls, and no further acknowledges or bias reads occur.
- R10: `start_i` and the configuration inputs are ignored while `busy_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture configuration and begin a run (idle only) |
| cfg_fc_i | input | 1 | 1 = group results into outputs (fully connected) |
| cfg_first_i | input | IDX_W | First neuron index of the polling window |
| cfg_count_i | input | NUM_W | Number of neurons in the window (0 treated as 1) |
| cfg_group_i | input | GRP_W | Results per output in fully connected mode (0 treated as 1) |
| cfg_outputs_i | input | OUT_W | Outputs to produce in the run (0 treated as 1) |
| cfg_bias_base_i | input | BIAS_AW | Bias memory address of output 0 |
| nrn_ready_i | input | N_NRN | Per-neuron result ready |
| nrn_data_i | input | N_NRN*DATA_W | Per-neuron results, neuron i at bits i*DATA_W +: DATA_W |
| nrn_ack_o | output | N_NRN | Per-neuron result taken pulse |
| bias_rd_en_o | output | 1 | Bias memory read strobe |
| bias_rd_addr_o | output | BIAS_AW | Bias memory read address |
| bias_rd_data_i | input | BIAS_W | Bias word, valid one cycle after the strobe |
| out_valid_o | output | 1 | Output holds a result |
| out_ready_i | input | 1 | Downstream accepts the result |
| out_data_o | output | DATA_W | Neuron result |
| out_bias_o | output | BIAS_W | Bias of the output this result belongs to |
| out_last_o | output | 1 | Finish marker: last part of an output |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse after the final handshake |

## Verification
A start sampled at edge k drives the bias strobe during the cycle after k. The bias word is latched at edge k+2. The first acknowledge can come in the cycle after that, and its result appears on the output one edge later. Each later output adds two bias cycles before polling resumes. `done_o` rises on the edge after the final handshake. Because the latency depends on backpressure and stalls, the bench does not count fixed cycles. It samples every output, acknowledge and bias strobe on the falling edge, records each handshake in order, and compares the recorded stream against a list computed from the configuration. Directed waits are bounded by timeouts.

// File: rtl/nrc_pkg.sv
package nrc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BREQ,
    ST_BLAT,
    ST_POLL,
    ST_DRAIN
  } nrc_state_e;
endpackage

// File: rtl/nrc_poll_ptr.sv
module nrc_poll_ptr #(
  parameter int N_NRN = 8,
  localparam int IDX_W = $clog2(N_NRN),
  localparam int NUM_W = $clog2(N_NRN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] first_i,
  input  logic [NUM_W-1:0] count_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] first_q, last_q, ptr_q;
  logic [NUM_W-1:0] cnt_eff;
  logic [IDX_W:0]   last_calc;

  assign cnt_eff   = (count_i == '0) ? NUM_W'(1) : count_i;
  assign last_calc = (IDX_W+1)'(first_i) + (IDX_W+1)'(cnt_eff) - (IDX_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= '0;
      last_q  <= '0;
      ptr_q   <= '0;
    end else if (load_i) begin
      first_q <= first_i;
      last_q  <= last_calc[IDX_W-1:0];
      ptr_q   <= first_i;
    end else if (adv_i) begin
      ptr_q <= (ptr_q == last_q) ? first_q : ptr_q + IDX_W'(1);
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/nrc_group_cnt.sv
module nrc_group_cnt #(
  parameter int GRP_W = 8,
  parameter int OUT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             fc_i,
  input  logic [GRP_W-1:0] group_i,
  input  logic [OUT_W-1:0] outputs_i,
  input  logic             step_i,
  output logic             last_part_o,
  output logic             final_o,
  output logic [OUT_W-1:0] out_idx_o
);
  logic             fc_q;
  logic [GRP_W-1:0] group_q, part_q;
  logic [OUT_W-1:0] outputs_q, idx_q;

  // zero-length settings behave as one
  assign last_part_o = !fc_q || ((GRP_W+1)'(part_q) + (GRP_W+1)'(1) >= (GRP_W+1)'(group_q));
  assign final_o     = last_part_o &&
                       ((OUT_W+1)'(idx_q) + (OUT_W+1)'(1) >= (OUT_W+1)'(outputs_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fc_q      <= 1'b0;
      group_q   <= '0;
      outputs_q <= '0;
      part_q    <= '0;
      idx_q     <= '0;
    end else if (load_i) begin
      fc_q      <= fc_i;
      group_q   <= group_i;
      outputs_q <= outputs_i;
      part_q    <= '0;
      idx_q     <= '0;
    end else if (step_i) begin
      if (last_part_o) begin
        part_q <= '0;
        idx_q  <= idx_q + OUT_W'(1);
      end else begin
        part_q <= part_q + GRP_W'(1);
      end
    end
  end

  assign out_idx_o = idx_q;
endmodule

// File: rtl/nrc_out_reg.sv
module nrc_out_reg #(
  parameter int DATA_W = 16,
  parameter int BIAS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BIAS_W-1:0] bias_i,
  input  logic              last_i,
  input  logic              ready_i,
  output logic              free_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [BIAS_W-1:0] bias_o,
  output logic              last_o
);
  logic valid_q;

  assign free_o  = !valid_q || ready_i;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_o  <= '0;
      bias_o  <= '0;
      last_o  <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_o  <= data_i;
      bias_o  <= bias_i;
      last_o  <= last_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/nrn_result_collector.sv
module nrn_result_collector
  import nrc_pkg::*;
#(
  parameter int N_NRN   = 8,
  parameter int DATA_W  = 16,
  parameter int BIAS_W  = 16,
  parameter int BIAS_AW = 6,
  parameter int GRP_W   = 8,
  parameter int OUT_W   = 8,
  localparam int IDX_W  = $clog2(N_NRN),
  localparam int NUM_W  = $clog2(N_NRN + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    cfg_fc_i,
  input  logic [IDX_W-1:0]        cfg_first_i,
  input  logic [NUM_W-1:0]        cfg_count_i,
  input  logic [GRP_W-1:0]        cfg_group_i,
  input  logic [OUT_W-1:0]        cfg_outputs_i,
  input  logic [BIAS_AW-1:0]      cfg_bias_base_i,
  input  logic [N_NRN-1:0]        nrn_ready_i,
  input  logic [N_NRN*DATA_W-1:0] nrn_data_i,
  output logic [N_NRN-1:0]        nrn_ack_o,
  output logic                    bias_rd_en_o,
  output logic [BIAS_AW-1:0]      bias_rd_addr_o,
  input  logic [BIAS_W-1:0]       bias_rd_data_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [DATA_W-1:0]       out_data_o,
  output logic [BIAS_W-1:0]       out_bias_o,
  output logic                    out_last_o,
  output logic                    busy_o,
  output logic                    done_o
);
  nrc_state_e         state_q, state_d;
  logic               load;
  logic               take;
  logic               out_free;
  logic               last_part, final_out;
  logic [IDX_W-1:0]   ptr;
  logic [OUT_W-1:0]   out_idx;
  logic [BIAS_W-1:0]  bias_q;
  logic [BIAS_AW-1:0] base_q;
  logic               cfg_fc_q;
  logic               done_q;
  logic [DATA_W-1:0]  sel_data;

  assign load     = (state_q == ST_IDLE) && start_i;
  assign take     = (state_q == ST_POLL) && nrn_ready_i[ptr] && out_free;
  assign sel_data = nrn_data_i[ptr*DATA_W +: DATA_W];

  nrc_poll_ptr #(.N_NRN(N_NRN)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .first_i (cfg_first_i),
    .count_i (cfg_count_i),
    .adv_i   (take),
    .ptr_o   (ptr)
  );

  nrc_group_cnt #(.GRP_W(GRP_W), .OUT_W(OUT_W)) u_grp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .fc_i        (cfg_fc_i),
    .group_i     (cfg_group_i),
    .outputs_i   (cfg_outputs_i),
    .step_i      (take),
    .last_part_o (last_part),
    .final_o     (final_out),
    .out_idx_o   (out_idx)
  );

  nrc_out_reg #(.DATA_W(DATA_W), .BIAS_W(BIAS_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (take),
    .data_i  (sel_data),
    .bias_i  (bias_q),
    .last_i  (last_part),
    .ready_i (out_ready_i),
    .free_o  (out_free),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .bias_o  (out_bias_o),
    .last_o  (out_last_o)
  );

  always_comb begin
    nrn_ack_o = '0;
    if (take) nrn_ack_o[ptr] = 1'b1;
  end

  assign bias_rd_en_o   = (state_q == ST_BREQ);
  assign bias_rd_addr_o = base_q + BIAS_AW'(out_idx);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_BREQ;
      ST_BREQ:  state_d = ST_BLAT;
      ST_BLAT:  state_d = ST_POLL;
      ST_POLL:  if (take && final_out) state_d = ST_DRAIN;
                else if (take && last_part) state_d = ST_BREQ;
      ST_DRAIN: if (out_valid_o && out_ready_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bias_q   <= '0;
      base_q   <= '0;
      cfg_fc_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_DRAIN) && out_valid_o && out_ready_i;
      if (load) begin
        base_q   <= cfg_bias_base_i;
        cfg_fc_q <= cfg_fc_i;
      end
      if (state_q == ST_BLAT) bias_q <= bias_rd_data_i;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/nrc_checker.sv
module nrc_checker #(
  parameter int N_NRN  = 8,
  parameter int DATA_W = 16,
  parameter int BIAS_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_NRN-1:0]  nrn_ready_i,
  input logic [N_NRN-1:0]  nrn_ack_i,
  input logic              bias_rd_en_i,
  input logic              out_valid_i,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_i,
  input logic [BIAS_W-1:0] out_bias_i,
  input logic              out_last_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              fc_q_i
);
  p_ack_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(nrn_ack_i));

  p_ack_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((nrn_ack_i & ~nrn_ready_i) == '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !out_ready_i) |=> (out_valid_i && $stable(out_data_i) &&
                                       $stable(out_bias_i) && $stable(out_last_i)));

  p_last_nonfc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !fc_q_i) |-> out_last_i);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (nrn_ack_i == '0 && !bias_rd_en_i));

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!busy_i && !out_valid_i));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
endmodule

bind nrn_result_collector nrc_checker #(
  .N_NRN(N_NRN), .DATA_W(DATA_W), .BIAS_W(BIAS_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .nrn_ready_i  (nrn_ready_i),
  .nrn_ack_i    (nrn_ack_o),
  .bias_rd_en_i (bias_rd_en_o),
  .out_valid_i  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_data_i   (out_data_o),
  .out_bias_i   (out_bias_o),
  .out_last_i   (out_last_o),
  .busy_i       (busy_o),
  .done_i       (done_o),
  .fc_q_i       (cfg_fc_q)
);

// File: tb/tb_nrn_result_collector.sv
`timescale 1ns/1ps
module tb_nrn_result_collector;
  localparam int N = 8, DW = 16, BW = 16, AW = 6, GW = 8, OW = 8, IW = 3, NW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          start;
  logic          cfg_fc;
  logic [IW-1:0] cfg_first;
  logic [NW-1:0] cfg_count;
  logic [GW-1:0] cfg_group;
  logic [OW-1:0] cfg_outputs;
  logic [AW-1:0] cfg_base;
  logic [N-1:0]  nrn_ready;
  logic [N*DW-1:0] nrn_data;
  logic [N-1:0]  nrn_ack;
  logic          bias_rd_en;
  logic [AW-1:0] bias_rd_addr;
  logic [BW-1:0] bias_rd_data;
  logic          out_valid, out_ready, out_last, busy, done;
  logic [DW-1:0] out_data;
  logic [BW-1:0] out_bias;

  nrn_result_collector dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_fc_i(cfg_fc),
    .cfg_first_i(cfg_first), .cfg_count_i(cfg_count), .cfg_group_i(cfg_group),
    .cfg_outputs_i(cfg_outputs), .cfg_bias_base_i(cfg_base),
    .nrn_ready_i(nrn_ready), .nrn_data_i(nrn_data), .nrn_ack_o(nrn_ack),
    .bias_rd_en_o(bias_rd_en), .bias_rd_addr_o(bias_rd_addr), .bias_rd_data_i(bias_rd_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_bias_o(out_bias), .out_last_o(out_last), .busy_o(busy), .done_o(done)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] bias_of(int a);
    return BW'(a * 5 + 100);
  endfunction

  // bias memory: one cycle read latency
  always @(posedge clk) if (bias_rd_en) bias_rd_data <= bias_of(int'(bias_rd_addr));

  // neuron models: each result counts how many times its neuron was acknowledged
  logic [7:0] cnt [N];
  logic       clr_cnt;
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (clr_cnt) cnt[i] <= 8'd0;
      else if (nrn_ack[i]) cnt[i] <= cnt[i] + 8'd1;
    end
  end
  for (genvar g = 0; g < N; g++) begin : g_nrn
    assign nrn_data[g*DW +: DW] = {8'(g), cnt[g]};
  end

  logic [31:0] cyc;
  always @(posedge clk) cyc <= cyc + 32'd1;

  logic bp_en, stall;
  assign out_ready = !bp_en || (cyc[1:0] != 2'd0);
  assign nrn_ready = stall ? ~(N'(1) << cfg_first) : '1;

  // monitor
  logic [DW-1:0] rec_data [64];
  logic [BW-1:0] rec_bias [64];
  logic          rec_last [64];
  int            rec_n;
  logic [AW-1:0] rec_addr [32];
  int            addr_n;
  logic          mon_en;
  logic          prev_hold;
  logic [DW-1:0] prev_data;
  logic [BW-1:0] prev_bias;
  logic          prev_last;

  always @(negedge clk) begin
    if (mon_en) begin
      if (prev_hold) begin
        chk(out_valid && out_data == prev_data && out_bias == prev_bias && out_last == prev_last,
            "R8", "held output changed under backpressure", int'(out_data), int'(prev_data));
      end
      chk($countones(nrn_ack) <= 1, "R4", "ack bits set", $countones(nrn_ack), 1);
      if (stall) chk(nrn_ack == '0, "R3", "ack while polled neuron stalled", int'(nrn_ack), 0);
      if (out_valid && out_ready && rec_n < 64) begin
        rec_data[rec_n] <= out_data;
        rec_bias[rec_n] <= out_bias;
        rec_last[rec_n] <= out_last;
        rec_n <= rec_n + 1;
      end
      if (bias_rd_en && addr_n < 32) begin
        rec_addr[addr_n] <= bias_rd_addr;
        addr_n <= addr_n + 1;
      end
      prev_hold <= out_valid && !out_ready;
      prev_data <= out_data;
      prev_bias <= out_bias;
      prev_last <= out_last;
    end else begin
      prev_hold <= 1'b0;
    end
  end

  task automatic run_case(bit fc, int first, int num, int grp, int nout, int base,
                          bit bp, int stall_cyc, bit restart);
    int gsz, to;
    @(negedge clk);
    clr_cnt = 1'b1; rec_n = 0; addr_n = 0; bp_en = bp;
    @(negedge clk);
    clr_cnt = 1'b0;
    cfg_fc = fc; cfg_first = IW'(first); cfg_count = NW'(num);
    cfg_group = GW'(grp); cfg_outputs = OW'(nout); cfg_base = AW'(base);
    stall = (stall_cyc > 0);
    start = 1'b1; mon_en = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (stall_cyc > 0) begin
      repeat (stall_cyc) @(negedge clk);
      chk(rec_n == 0 && busy, "R3", "outputs during stall", rec_n, 0);
      stall = 1'b0;
    end
    if (restart) begin
      repeat (4) @(negedge clk);
      cfg_fc = ~fc; cfg_first = IW'(first + 1); cfg_count = NW'(1);
      cfg_outputs = OW'(1); cfg_base = AW'(base + 9);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    to = 0;
    while (!done && to < 3000) begin
      @(negedge clk);
      to++;
    end
    mon_en = 1'b0;
    chk(done, "R9", "done pulse seen", int'(done), 1);
    gsz = fc ? grp : 1;
    chk(rec_n == nout * gsz, "R9", "handshake count", rec_n, nout * gsz);
    chk(addr_n == nout, "R7", "bias read count", addr_n, nout);
    for (int o = 0; o < nout; o++) begin
      if (o < addr_n)
        chk(int'(rec_addr[o]) == base + o, "R7", "bias address", int'(rec_addr[o]), base + o);
      for (int p = 0; p < gsz; p++) begin
        int k, nid, occ;
        logic [DW-1:0] ed;
        k = o * gsz + p;
        nid = first + (k % num);
        occ = k / num;
        ed = {8'(nid), 8'(occ)};
        if (k < rec_n) begin
          chk(rec_data[k] == ed, "R2", "result order/data", int'(rec_data[k]), int'(ed));
          chk(rec_bias[k] == bias_of(base + o), "R7", "bias attached", int'(rec_bias[k]),
              int'(bias_of(base + o)));
          chk(rec_last[k] == (p == gsz - 1), fc ? "R6" : "R5", "finish marker",
              int'(rec_last[k]), int'(p == gsz - 1));
        end
      end
    end
    @(negedge clk);
    chk(!busy && !out_valid && !done, "R9", "idle after done", int'({busy, out_valid, done}), 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(nrn_ack == '0 && !bias_rd_en, "R9", "activity after done", int'(nrn_ack), 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid && nrn_ack == '0 && !bias_rd_en && !busy && !done, "R1",
        "outputs in reset", int'({out_valid, bias_rd_en, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && nrn_ack == '0 && !bias_rd_en && !busy && !done, "R1",
        "outputs after reset", int'({out_valid, bias_rd_en, busy, done}), 0);
  endtask

  // R2 R5 R7: plain cyclic order, every result complete
  task automatic t_basic();       run_case(1'b0, 0, 4, 1, 6, 3, 1'b0, 0, 1'b0); endtask
  // R2 R8: window at top of range, wrap, backpressure
  task automatic t_window_bp();   run_case(1'b0, 5, 3, 1, 7, 20, 1'b1, 0, 1'b0); endtask
  // R6 R7 R8: grouped outputs under backpressure
  task automatic t_fc_groups();   run_case(1'b1, 1, 4, 3, 4, 40, 1'b1, 0, 1'b0); endtask
  // R3: first neuron late while the others are ready
  task automatic t_stall();       run_case(1'b0, 2, 4, 1, 5, 0, 1'b0, 20, 1'b0); endtask
  // R10: restart attempt with different settings mid-run
  task automatic t_restart();     run_case(1'b1, 0, 3, 2, 3, 10, 1'b1, 0, 1'b1); endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_fc = 1'b0; cfg_first = '0; cfg_count = '0;
    cfg_group = '0; cfg_outputs = '0; cfg_base = '0; bp_en = 1'b0; stall = 1'b0;
    mon_en = 1'b0; clr_cnt = 1'b1; rec_n = 0; addr_n = 0; cyc = '0; bias_rd_data = '0;
    t_reset();
    t_basic();
    t_window_bp();
    t_fc_groups();
    t_stall();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule